// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide register front end of an eight-line interrupt controller. A main port with two addresses accepts setup words and run-time control words. A separate select line reaches a trigger-mode register. Each write is decoded into held state for the controller core: the line mask, the vector base, and the mode bits (auto-EOI, special fully nested, special mask, rotate on auto-EOI). Some writes instead become single-cycle command pulses: core reset, end-of-interrupt in its plain, specific and rotating forms, and set-priority.

A setup word on address 0 starts a short sequence of further writes on address 1. Those writes load the vector base, consume a cascade word and load the mode word. The cascade word and the mode word are each skipped or required according to two flags captured from the setup word. Reads return data in the same cycle as the strobe. The data is the request or in-service vector supplied by the core, the mask, or the trigger-mode register. A read can also be a poll: it acknowledges the core's current winner and reports it.

Priority resolution lives in the core. This block only receives the winner (a valid flag and a line number) and passes the acknowledge back.

Top module: `pic_cmd_if`

## Requirements
- R1: A write to address 0 with bit 4 set pulses `core_reset_o` in the same cycle. From the next cycle, the mask, special fully nested, auto-EOI, special mask, rotate-on-auto-EOI, poll and read-select bits are all zero. The write captures "mode word needed" from bit 0 and "single" from bit 1. The next address-1 write is the vector-base write.
- R2: The vector-base write loads `vec_base_o` from data bits 7:3. The next state is the cascade word when single is 0. When single is 1, the next state is the mode word if "mode word needed" is set, and normal operation otherwise.
- R3: The cascade-word write changes no output. It is followed by the mode word if "mode word needed" is set, and by normal operation otherwise.
- R4: The mode-word write sets `sfnm_o` from bit 4 and `auto_eoi_o` from bit 1, then returns to normal operation.
- R5: In normal operation, an address-1 write loads `mask_o`. No other kind of write changes the mask.
- R6: A write to address 0 with bit 4 clear and bit 3 set is a control word. Bit 2 arms poll. If bit 1 is set, bit 0 sets the read select (1 = in-service, 0 = request). If bit 6 is set, bit 5 sets `special_mask_o`. Fields whose enable bit is clear keep their value.
- R7: A write to address 0 with bits 4 and 3 clear is decoded on bits 7:5, and the pulses are valid in the write cycle. Codes 0 and 4 set `rot_aeoi_o` to bit 7. Code 1 pulses `cmd_eoi_o`. Code 5 pulses `cmd_eoi_o` and `cmd_rotate_o`. Code 3 pulses `cmd_eoi_o` and `cmd_specific_o`, with `cmd_line_o` taken from bits 2:0. Code 7 pulses all three. Code 6 pulses `cmd_setprio_o` with `cmd_line_o` from bits 2:0. Code 2 has no effect.
- R8: With poll armed, the next main-port read returns 0x80 OR the winner line, and pulses `ack_o` with `ack_line_o` set to that line, if `win_valid_i` is high. Otherwise it returns 0 and does not acknowledge. Either way the read disarms poll.
- R9: With poll not armed, a read of address 0 returns `isr_i` when the read select is 1 and `irr_i` when it is 0. A read of address 1 returns the mask.
- R10: A trigger-port write stores the data AND `TRIG_WMASK`, and a trigger-port read returns the stored value. The register clears on reset and is not affected by the setup word.
- R11: `rdata_o` is 0 in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Main port select |
| tcs_i | input | 1 | Trigger-mode port select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 1 | Main port address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, same cycle as the read strobe |
| irr_i | input | 8 | Request vector from the core |
| isr_i | input | 8 | In-service vector from the core |
| win_valid_i | input | 1 | Core has a winning line |
| win_line_i | input | 3 | Winning line number |
| core_reset_o | output | 1 | Core reset pulse |
| mask_o | output | 8 | Line mask |
| vec_base_o | output | 5 | Vector base (upper five bits) |
| auto_eoi_o | output | 1 | Auto-EOI mode |
| sfnm_o | output | 1 | Special fully nested mode |
| rot_aeoi_o | output | 1 | Rotate on auto-EOI |
| special_mask_o | output | 1 | Special mask mode |
| cmd_eoi_o | output | 1 | End-of-interrupt pulse |
| cmd_specific_o | output | 1 | EOI names a line |
| cmd_rotate_o | output | 1 | EOI also rotates priority |
| cmd_setprio_o | output | 1 | Set-priority pulse |
| cmd_line_o | output | 3 | Line for specific EOI or set-priority |
| ack_o | output | 1 | Poll acknowledge pulse |
| ack_line_o | output | 3 | Line being acknowledged |
| trig_mode_o | output | 8 | Trigger-mode register |

## Verification
On every cycle, the assertions check several rules: the command pulses stay mutually exclusive, the EOI qualifiers never appear without an EOI, and the mask holds without a write. They also check that a setup word leaves every mode bit cleared, that an acknowledge comes only from an armed poll read with the winner encoded in the read data, and that a poll read disarms poll. In addition, the trigger register never holds a bit outside its writable mask, and the read bus is idle without a strobe. Only the directed scenarios can show that the setup sequence skips the right words in all four combinations of the single and mode-word flags, and that each command code maps to its pulses. The same holds for the read select and special mask keeping their value when their enable bits are clear, and for a poll with nothing pending returning zero and handing the next read back to the normal registers.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int LINES  = 8;
  localparam int LINE_W = $clog2(LINES);
  localparam int BASE_W = BYTE_W - LINE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [LINE_W-1:0] line_t;

  typedef enum logic [1:0] {
    IS_RUN  = 2'd0,
    IS_BASE = 2'd1,
    IS_CASC = 2'd2,
    IS_MODE = 2'd3
  } init_st_e;

  typedef enum logic [2:0] {
    OP_ROT_CLR = 3'd0,
    OP_EOI     = 3'd1,
    OP_NOP     = 3'd2,
    OP_SEOI    = 3'd3,
    OP_ROT_SET = 3'd4,
    OP_REOI    = 3'd5,
    OP_SETPRI  = 3'd6,
    OP_RSEOI   = 3'd7
  } op_code_e;

  function automatic logic is_setup_word(byte_t d);
    return d[4];
  endfunction

  function automatic logic is_ctrl_word(byte_t d);
    return !d[4] && d[3];
  endfunction

  function automatic logic is_op_word(byte_t d);
    return !d[4] && !d[3];
  endfunction

  function automatic init_st_e after_base(logic single, logic need_mode);
    if (!single) return IS_CASC;
    return need_mode ? IS_MODE : IS_RUN;
  endfunction

  function automatic init_st_e after_casc(logic need_mode);
    return need_mode ? IS_MODE : IS_RUN;
  endfunction

  function automatic byte_t poll_word(logic valid, line_t line);
    if (!valid) return '0;
    return {1'b1, {(BYTE_W-1-LINE_W){1'b0}}, line};
  endfunction
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a0,
  input  logic              wr_a1,
  input  byte_t             wdata,
  output logic              setup_hit,
  output byte_t             mask,
  output logic [BASE_W-1:0] base,
  output logic              sfnm,
  output logic              aeoi
);
  init_st_e state;
  logic     need_mode;
  logic     single;

  always_comb setup_hit = wr_a0 && is_setup_word(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IS_RUN;
      need_mode <= 1'b0;
      single    <= 1'b0;
      mask      <= '0;
      base      <= '0;
      sfnm      <= 1'b0;
      aeoi      <= 1'b0;
    end else if (setup_hit) begin
      state     <= IS_BASE;
      need_mode <= wdata[0];
      single    <= wdata[1];
      mask      <= '0;
      sfnm      <= 1'b0;
      aeoi      <= 1'b0;
    end else if (wr_a1) begin
      unique case (state)
        IS_RUN:  mask <= wdata;
        IS_BASE: begin
          base  <= wdata[BYTE_W-1:LINE_W];
          state <= after_base(single, need_mode);
        end
        IS_CASC: state <= after_casc(need_mode);
        IS_MODE: begin
          sfnm  <= wdata[4];
          aeoi  <= wdata[1];
          state <= IS_RUN;
        end
        default: state <= IS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pic_ctrl_dec.sv
module pic_ctrl_dec
  import pic_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_a0,
  input  logic  rd_main,
  input  logic  setup_hit,
  input  byte_t wdata,
  output logic  poll,
  output logic  rsel,
  output logic  smm,
  output logic  rot_aeoi,
  output logic  cmd_eoi,
  output logic  cmd_spec,
  output logic  cmd_rot,
  output logic  cmd_setprio,
  output line_t cmd_line
);
  op_code_e op;
  logic     op_wr;
  logic     ctrl_wr;

  always_comb begin
    op          = op_code_e'(wdata[7:5]);
    op_wr       = wr_a0 && is_op_word(wdata);
    ctrl_wr     = wr_a0 && is_ctrl_word(wdata);
    cmd_line    = wdata[LINE_W-1:0];
    cmd_eoi     = 1'b0;
    cmd_spec    = 1'b0;
    cmd_rot     = 1'b0;
    cmd_setprio = 1'b0;
    if (op_wr) begin
      unique case (op)
        OP_EOI:    cmd_eoi = 1'b1;
        OP_REOI:   begin cmd_eoi = 1'b1; cmd_rot = 1'b1; end
        OP_SEOI:   begin cmd_eoi = 1'b1; cmd_spec = 1'b1; end
        OP_RSEOI:  begin cmd_eoi = 1'b1; cmd_spec = 1'b1; cmd_rot = 1'b1; end
        OP_SETPRI: cmd_setprio = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll     <= 1'b0;
      rsel     <= 1'b0;
      smm      <= 1'b0;
      rot_aeoi <= 1'b0;
    end else if (setup_hit) begin
      poll     <= 1'b0;
      rsel     <= 1'b0;
      smm      <= 1'b0;
      rot_aeoi <= 1'b0;
    end else begin
      if (rd_main && poll) poll <= 1'b0;
      if (ctrl_wr) begin
        if (wdata[2]) poll <= 1'b1;
        if (wdata[1]) rsel <= wdata[0];
        if (wdata[6]) smm  <= wdata[5];
      end
      if (op_wr && (op == OP_ROT_CLR || op == OP_ROT_SET)) rot_aeoi <= wdata[7];
    end
  end
endmodule

// File: rtl/pic_trig_reg.sv
module pic_trig_reg
  import pic_cmd_pkg::*;
#(
  parameter byte_t WMASK = 8'hF8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  byte_t wdata,
  output byte_t value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (wr_en) value <= wdata & WMASK;
  end
endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
  import pic_cmd_pkg::*;
#(
  parameter logic [7:0] TRIG_WMASK = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_i,
  input  logic       tcs_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [7:0] irr_i,
  input  logic [7:0] isr_i,
  input  logic       win_valid_i,
  input  logic [2:0] win_line_i,
  output logic       core_reset_o,
  output logic [7:0] mask_o,
  output logic [4:0] vec_base_o,
  output logic       auto_eoi_o,
  output logic       sfnm_o,
  output logic       rot_aeoi_o,
  output logic       special_mask_o,
  output logic       cmd_eoi_o,
  output logic       cmd_specific_o,
  output logic       cmd_rotate_o,
  output logic       cmd_setprio_o,
  output logic [2:0] cmd_line_o,
  output logic       ack_o,
  output logic [2:0] ack_line_o,
  output logic [7:0] trig_mode_o
);
  logic  wr_a0, wr_a1, rd_main, trig_wr, trig_rd;
  logic  poll_armed, read_isr;
  byte_t main_rd;

  assign wr_a0   = cs_i && wr_i && !addr_i;
  assign wr_a1   = cs_i && wr_i && addr_i;
  assign rd_main = cs_i && rd_i;
  assign trig_wr = tcs_i && wr_i;
  assign trig_rd = tcs_i && rd_i;

  pic_init_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_a0     (wr_a0),
    .wr_a1     (wr_a1),
    .wdata     (wdata_i),
    .setup_hit (core_reset_o),
    .mask      (mask_o),
    .base      (vec_base_o),
    .sfnm      (sfnm_o),
    .aeoi      (auto_eoi_o)
  );

  pic_ctrl_dec u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_a0       (wr_a0),
    .rd_main     (rd_main),
    .setup_hit   (core_reset_o),
    .wdata       (wdata_i),
    .poll        (poll_armed),
    .rsel        (read_isr),
    .smm         (special_mask_o),
    .rot_aeoi    (rot_aeoi_o),
    .cmd_eoi     (cmd_eoi_o),
    .cmd_spec    (cmd_specific_o),
    .cmd_rot     (cmd_rotate_o),
    .cmd_setprio (cmd_setprio_o),
    .cmd_line    (cmd_line_o)
  );

  pic_trig_reg #(.WMASK(TRIG_WMASK)) u_trig (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (trig_wr),
    .wdata (wdata_i),
    .value (trig_mode_o)
  );

  always_comb begin
    if (poll_armed)  main_rd = poll_word(win_valid_i, win_line_i);
    else if (addr_i) main_rd = mask_o;
    else             main_rd = read_isr ? isr_i : irr_i;
  end

  assign rdata_o    = trig_rd ? trig_mode_o : (rd_main ? main_rd : '0);
  assign ack_o      = rd_main && poll_armed && win_valid_i;
  assign ack_line_o = win_line_i;
endmodule

// File: rtl/pic_cmd_if_chk.sv
module pic_cmd_if_chk #(
  parameter logic [7:0] TRIG_WMASK = 8'hF8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] rdata_o,
  input logic       win_valid_i,
  input logic [2:0] win_line_i,
  input logic       core_reset_o,
  input logic [7:0] mask_o,
  input logic       auto_eoi_o,
  input logic       sfnm_o,
  input logic       rot_aeoi_o,
  input logic       special_mask_o,
  input logic       cmd_eoi_o,
  input logic       cmd_specific_o,
  input logic       cmd_rotate_o,
  input logic       cmd_setprio_o,
  input logic       ack_o,
  input logic [2:0] ack_line_o,
  input logic [7:0] trig_mode_o,
  input logic       poll_armed
);
  a_r1_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_o |=> (mask_o == 8'h00) && !auto_eoi_o && !sfnm_o
                     && !special_mask_o && !rot_aeoi_o && !poll_armed);

  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_i && wr_i) |=> $stable(mask_o));

  a_r7_one_command: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_reset_o, cmd_eoi_o, cmd_setprio_o}));

  a_r7_qualifiers: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_specific_o || cmd_rotate_o) |-> cmd_eoi_o);

  a_r8_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> cs_i && rd_i && poll_armed && win_valid_i && ack_line_o == win_line_i
              && rdata_o == {5'b10000, win_line_i});

  a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && rd_i && !wr_i && poll_armed) |=> !poll_armed);

  a_r10_trig_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode_o & ~TRIG_WMASK) == 8'h00);

  a_r11_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |-> rdata_o == 8'h00);
endmodule

bind pic_cmd_if pic_cmd_if_chk #(.TRIG_WMASK(TRIG_WMASK)) u_chk (.*);

// File: tb/sim_pic_cmd_if.sv
module sim_pic_cmd_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, tcs = 1'b0, wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00, irr = 8'h00, isr = 8'h00;
  logic       wvalid = 1'b0;
  logic [2:0] wline = 3'd0;
  logic [7:0] rdata, mask, trig;
  logic [4:0] vbase;
  logic       crst, aeoi, sfnm, raeoi, smm, ceoi, cspec, crot, csp, ack;
  logic [2:0] cline, ackl;

  logic [7:0] c_rd;
  logic       c_rst, c_eoi, c_spec, c_rot, c_sp, c_ack;
  logic [2:0] c_line, c_ackl;

  int ntests = 0;
  int nfail  = 0;

  always #5 clk = ~clk;

  pic_cmd_if #(.TRIG_WMASK(8'hF8)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .tcs_i(tcs), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irr_i(irr), .isr_i(isr),
    .win_valid_i(wvalid), .win_line_i(wline), .core_reset_o(crst), .mask_o(mask),
    .vec_base_o(vbase), .auto_eoi_o(aeoi), .sfnm_o(sfnm), .rot_aeoi_o(raeoi),
    .special_mask_o(smm), .cmd_eoi_o(ceoi), .cmd_specific_o(cspec),
    .cmd_rotate_o(crot), .cmd_setprio_o(csp), .cmd_line_o(cline), .ack_o(ack),
    .ack_line_o(ackl), .trig_mode_o(trig)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic to_trig, input logic is_wr, input logic a, input logic [7:0] d);
    @(negedge clk);
    cs = !to_trig; tcs = to_trig; wr = is_wr; rd = !is_wr; addr = a; wdata = d;
    #1;
    c_rd = rdata; c_rst = crst; c_eoi = ceoi; c_spec = cspec; c_rot = crot;
    c_sp = csp; c_line = cline; c_ack = ack; c_ackl = ackl;
    @(posedge clk);
    #1;
    cs = 1'b0; tcs = 1'b0; wr = 1'b0; rd = 1'b0; addr = 1'b0; wdata = 8'h00;
  endtask

  task automatic wr0(input logic [7:0] d); bus(1'b0, 1'b1, 1'b0, d); endtask
  task automatic wr1(input logic [7:0] d); bus(1'b0, 1'b1, 1'b1, d); endtask
  task automatic rdm(input logic a);       bus(1'b0, 1'b0, a, 8'h00); endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    chk("R11 idle bus after reset", rdata, 8'h00);
    chk("R5 mask after reset", mask, 8'h00);
    chk("R10 trig after reset", trig, 8'h00);
    rdm(1'b1);
    chk("R9 mask read after reset", c_rd, 8'h00);
  endtask

  task automatic t_setup_full();
    wr0(8'h11);
    chk("R1 core reset pulse", c_rst, 1'b1);
    wr1(8'h48);
    chk("R2 base write no reset pulse", c_rst, 1'b0);
    chk("R2 base from bits 7:3", vbase, 5'd9);
    wr1(8'hAA);
    chk("R3 cascade word leaves mask", mask, 8'h00);
    chk("R3 cascade word leaves base", vbase, 5'd9);
    wr1(8'h12);
    chk("R4 sfnm from bit 4", sfnm, 1'b1);
    chk("R4 auto-EOI from bit 1", aeoi, 1'b1);
    wr1(8'h5A);
    chk("R5 mask load in run", mask, 8'h5A);
    chk("R4 mode untouched by mask write", {sfnm, aeoi}, 2'b11);
  endtask

  task automatic t_setup_single();
    wr1(8'hFF);
    wr0(8'h80);
    wr0(8'h13);
    chk("R1 mask cleared by setup", mask, 8'h00);
    chk("R1 modes cleared by setup", {sfnm, aeoi, raeoi}, 3'b000);
    wr1(8'h20);
    chk("R2 single base", vbase, 5'd4);
    wr1(8'h02);
    chk("R2 single skips to mode word", {sfnm, aeoi}, 2'b01);
    chk("R4 mode word leaves mask", mask, 8'h00);
    wr1(8'h33);
    chk("R5 mask after single+mode", mask, 8'h33);
    wr0(8'h12);
    wr1(8'hF8);
    chk("R2 single no mode base", vbase, 5'd31);
    wr1(8'h0F);
    chk("R2 single no mode goes to run", mask, 8'h0F);
    wr0(8'h10);
    wr1(8'h08);
    chk("R2 cascaded base", vbase, 5'd1);
    wr1(8'h04);
    chk("R3 cascade word consumed", mask, 8'h00);
    wr1(8'h77);
    chk("R3 no mode word then run", mask, 8'h77);
    chk("R4 mode bits stay clear", {sfnm, aeoi}, 2'b00);
  endtask

  task automatic t_ctrl_word();
    irr = 8'h21; isr = 8'h84;
    rdm(1'b0);
    chk("R9 default select is request", c_rd, 8'h21);
    wr0(8'h0B);
    rdm(1'b0);
    chk("R9 select in-service", c_rd, 8'h84);
    wr0(8'h08);
    rdm(1'b0);
    chk("R6 select kept when bit1 clear", c_rd, 8'h84);
    wr0(8'h0A);
    rdm(1'b0);
    chk("R9 select request", c_rd, 8'h21);
    rdm(1'b1);
    chk("R9 address 1 returns mask", c_rd, 8'h77);
    wr0(8'h68);
    chk("R6 special mask set", smm, 1'b1);
    wr0(8'h28);
    chk("R6 special mask kept when bit6 clear", smm, 1'b1);
    wr0(8'h48);
    chk("R6 special mask clear", smm, 1'b0);
    wr1(8'h55);
    wr0(8'h08);
    chk("R5 control word leaves mask", mask, 8'h55);
  endtask

  task automatic t_commands();
    wr0(8'h20);
    chk("R7 code1 plain EOI", {c_eoi, c_spec, c_rot, c_sp}, 4'b1000);
    wr0(8'hA0);
    chk("R7 code5 rotating EOI", {c_eoi, c_spec, c_rot, c_sp}, 4'b1010);
    wr0(8'h65);
    chk("R7 code3 specific EOI", {c_eoi, c_spec, c_rot, c_sp}, 4'b1100);
    chk("R7 code3 line", c_line, 3'd5);
    wr0(8'hE3);
    chk("R7 code7 rotating specific", {c_eoi, c_spec, c_rot, c_sp}, 4'b1110);
    chk("R7 code7 line", c_line, 3'd3);
    wr0(8'hC6);
    chk("R7 code6 set priority", {c_eoi, c_spec, c_rot, c_sp}, 4'b0001);
    chk("R7 code6 line", c_line, 3'd6);
    wr0(8'h47);
    chk("R7 code2 no pulse", {c_eoi, c_spec, c_rot, c_sp, c_rst}, 5'b00000);
    chk("R7 code2 no state change", {raeoi, smm, mask}, {2'b00, 8'h55});
    wr0(8'h80);
    chk("R7 code4 rotate on auto-EOI", raeoi, 1'b1);
    wr0(8'h00);
    chk("R7 code0 clears rotate on auto-EOI", raeoi, 1'b0);
    wr1(8'h01);
    chk("R7 address-1 write no pulse", {c_eoi, c_sp}, 2'b00);
  endtask

  task automatic t_poll();
    irr = 8'h42;
    wvalid = 1'b1; wline = 3'd5;
    wr0(8'h0C);
    rdm(1'b0);
    chk("R8 poll read data", c_rd, 8'h85);
    chk("R8 poll ack", {c_ack, c_ackl}, {1'b1, 3'd5});
    rdm(1'b0);
    chk("R8 poll disarmed after read", c_rd, 8'h42);
    chk("R8 no ack after disarm", c_ack, 1'b0);
    wvalid = 1'b0;
    wr0(8'h0C);
    rdm(1'b1);
    chk("R8 poll nothing pending reads 0", c_rd, 8'h00);
    chk("R8 no ack when nothing pending", c_ack, 1'b0);
    rdm(1'b1);
    chk("R8 empty poll also disarms", c_rd, 8'h01);
  endtask

  task automatic t_trig();
    bus(1'b1, 1'b1, 1'b0, 8'hFF);
    bus(1'b1, 1'b0, 1'b0, 8'h00);
    chk("R10 trig write masked", c_rd, 8'hF8);
    bus(1'b1, 1'b1, 1'b0, 8'h6B);
    chk("R10 trig value", trig, 8'h68);
    wr0(8'h11);
    bus(1'b1, 1'b0, 1'b0, 8'h00);
    chk("R10 trig kept over setup word", c_rd, 8'h68);
    do_reset();
    #1;
    chk("R10 trig cleared by reset", trig, 8'h00);
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setup_full();
    t_setup_single();
    t_ctrl_word();
    t_commands();
    t_poll();
    t_trig();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule